// File: doc/BRIEF.md
# Link Speed Change Controller

This block supervises one request to move a serial link from its base signalling rate to a faster one. Software uses a small 32-bit register bus to read the current and maximum link speed, select the reason for the change and start it. The block then holds a request towards a link-training agent until that agent reports the outcome. The outcome is recorded in three sticky write-1-to-clear flags (finished, succeeded, failed), and the speed field takes the rate the agent reports. The finished flag feeds a two-level interrupt: a local enable gates it into a top-level status bit, and a top-level enable gates that bit onto the interrupt pin.

A failed change locks out further changes until the link reports that it is back in its normal operating state (L0). A holdoff of `HOLDOFF_CYCLES` clock cycles then runs before a new start is accepted. A start write is ignored while a change is pending or unacknowledged, during the lockout and during the holdoff.

The behaviour is one state machine with four states:
- `ST_IDLE`: waiting for a start.
- `ST_TRAIN`: the request is held.
- `ST_LOCKED`: after a failure, waiting for L0.
- `ST_HOLDOFF`: counting the wait.

Its transitions are:
- IDLE→TRAIN on an accepted start.
- TRAIN→IDLE on a successful completion.
- TRAIN→LOCKED on a failed completion.
- LOCKED→HOLDOFF when L0 is seen.
- HOLDOFF→IDLE when the count expires.

Top module: `link_rate_ctrl`

## Requirements
- R1: After reset the registers read as follows. STATUS (word 0) reads 0x0001_0000: speed code 1 in bits 19:16 and flags clear. CTRL (word 1), LOCAL_EN (word 4), TOP_STAT (word 5) and TOP_EN (word 6) read 0. REASON (word 3) reads 0x8000_0000. `train_req` and `irq` are 0.
- R2: A write to CTRL with bit 24 set is accepted while the block is idle and no change is pending. From the next cycle, CTRL bit 24 reads 1 and `train_req` is 1 until the agent completes.
- R3: The cycle after `train_done` is sampled with `train_req` high, three things hold. STATUS bit 4 (finished) is 1. Exactly one of bit 7 (succeeded, when `train_ok`=1) and bit 6 (failed, when `train_ok`=0) is 1. CTRL bit 24 and `train_req` are 0.
- R4: On success, STATUS bits 19:16 take `train_speed`. On failure they keep their previous value. Speed codes are 1 for 2.5 GT/s and 2 for 5 GT/s.
- R5: Writing 1 to STATUS bit 4, 6 or 7 clears that flag. Writing 0 to a flag leaves it unchanged.
- R6: A start write is ignored while the finished flag is set or CTRL bit 24 already reads 1.
- R7: CAP (word 2) reports `link_cap_speed` in bits 19:16 and 0 elsewhere. Writes to it have no effect.
- R8: REASON bit 31 is readable and writable and drives `train_reason`. A value of 0 marks an intentional change.
- R9: TOP_STAT bit 13 equals finished AND LOCAL_EN bit 4. `irq` equals TOP_STAT bit 13 AND TOP_EN bit 13. Clearing either enable or the finished flag drops `irq`.
- R10: After a failure, start writes are ignored until `link_in_l0` is sampled high. They stay ignored for `HOLDOFF_CYCLES` further cycles. A start in the cycle after the holdoff is accepted.
- R11: A start write ignored during the lockout or holdoff sets no flag and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| link_cap_speed | input | 4 | Highest speed code the link supports |
| train_req | output | 1 | Speed change request to the training agent |
| train_reason | output | 1 | Reason bit passed with the request |
| train_done | input | 1 | Agent completion pulse |
| train_ok | input | 1 | Completion outcome, 1 for success |
| train_speed | input | 4 | Speed code reached, valid with `train_done` |
| link_in_l0 | input | 1 | Link has re-entered L0 |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with `HOLDOFF_CYCLES` = 20 instead of the default of 40,000,000 cycles. This makes the end of the post-failure holdoff reachable in a short run. With it, the last refused start and the first accepted start, one cycle apart, can both be hit exactly. Failures occur several times in one run, so the lockout, holdoff and return to idle are exercised repeatedly, interleaved with successes at different speed codes.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TRAIN   = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_HOLDOFF = 2'd3
    } lrc_state_e;

    // register word indices
    localparam int A_STATUS   = 0;
    localparam int A_CTRL     = 1;
    localparam int A_CAP      = 2;
    localparam int A_REASON   = 3;
    localparam int A_LOCAL_EN = 4;
    localparam int A_TOP_STAT = 5;
    localparam int A_TOP_EN   = 6;

    // bit positions
    localparam int B_FIN    = 4;
    localparam int B_FAIL   = 6;
    localparam int B_SUCC   = 7;
    localparam int B_SPD_LO = 16;
    localparam int SPD_W    = 4;
    localparam int B_START  = 24;
    localparam int B_REASON = 31;
    localparam int B_MACIRQ = 13;

    localparam logic [SPD_W-1:0] SPD_BASE = 4'd1;

endpackage

// File: rtl/lrc_fsm.sv
module lrc_fsm
    import lrc_pkg::*;
#(
    parameter int HOLDOFF_CYCLES = 40_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic fin_pending,
    input  logic start_busy,
    input  logic train_done,
    input  logic train_ok,
    input  logic link_in_l0,
    output logic accept,
    output logic finish,
    output logic finish_ok,
    output logic train_req
);

    localparam int CNT_W = $clog2(HOLDOFF_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLDOFF_CYCLES - 1);

    lrc_state_e state_q, state_d;
    logic [CNT_W-1:0] hold_cnt;
    logic cnt_last;

    assign cnt_last = (hold_cnt == CNT_LAST);

    // state register and holdoff counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hold_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLDOFF)
                hold_cnt <= hold_cnt + 1'b1;
            else
                hold_cnt <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_wr && !fin_pending && !start_busy) state_d = ST_TRAIN;
            ST_TRAIN:   if (train_done) state_d = train_ok ? ST_IDLE : ST_LOCKED;
            ST_LOCKED:  if (link_in_l0) state_d = ST_HOLDOFF;
            ST_HOLDOFF: if (cnt_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        finish    = 1'b0;
        finish_ok = 1'b0;
        train_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = start_wr && !fin_pending && !start_busy;
            ST_TRAIN: begin
                train_req = 1'b1;
                finish    = train_done;
                finish_ok = train_done && train_ok;
            end
            ST_LOCKED, ST_HOLDOFF: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/lrc_irq.sv
module lrc_irq (
    input  logic fin_flag,
    input  logic local_en,
    input  logic top_en,
    output logic top_stat,
    output logic irq
);

    assign top_stat = fin_flag & local_en;
    assign irq      = top_stat & top_en;

endmodule

// File: rtl/lrc_regs.sv
module lrc_regs
    import lrc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [SPD_W-1:0]  link_cap_speed,
    input  logic [SPD_W-1:0]  train_speed,
    input  logic              accept,
    input  logic              finish,
    input  logic              finish_ok,
    input  logic              top_stat,
    output logic              start_wr,
    output logic              fin_flag,
    output logic              succ_flag,
    output logic              fail_flag,
    output logic              start_bit,
    output logic [SPD_W-1:0]  cur_speed,
    output logic              reason_bit,
    output logic              local_en,
    output logic              top_en
);

    logic wr_status, wr_reason, wr_local, wr_top;
    logic unused_wdata;

    assign wr_status = reg_we && (reg_addr == ADDR_W'(A_STATUS));
    assign wr_reason = reg_we && (reg_addr == ADDR_W'(A_REASON));
    assign wr_local  = reg_we && (reg_addr == ADDR_W'(A_LOCAL_EN));
    assign wr_top    = reg_we && (reg_addr == ADDR_W'(A_TOP_EN));
    assign start_wr  = reg_we && (reg_addr == ADDR_W'(A_CTRL)) && reg_wdata[B_START];
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin_flag   <= 1'b0;
            succ_flag  <= 1'b0;
            fail_flag  <= 1'b0;
            start_bit  <= 1'b0;
            cur_speed  <= SPD_BASE;
            reason_bit <= 1'b1;
            local_en   <= 1'b0;
            top_en     <= 1'b0;
        end else begin
            if (wr_status) begin
                if (reg_wdata[B_FIN])  fin_flag  <= 1'b0;
                if (reg_wdata[B_SUCC]) succ_flag <= 1'b0;
                if (reg_wdata[B_FAIL]) fail_flag <= 1'b0;
            end
            // a completion in the same cycle takes precedence over a clear
            if (finish) begin
                fin_flag  <= 1'b1;
                succ_flag <= finish_ok;
                fail_flag <= !finish_ok;
                if (finish_ok) cur_speed <= train_speed;
            end
            if (accept)      start_bit <= 1'b1;
            else if (finish) start_bit <= 1'b0;
            if (wr_reason) reason_bit <= reg_wdata[B_REASON];
            if (wr_local)  local_en   <= reg_wdata[B_FIN];
            if (wr_top)    top_en     <= reg_wdata[B_MACIRQ];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_STATUS): begin
                reg_rdata[B_FIN]  = fin_flag;
                reg_rdata[B_FAIL] = fail_flag;
                reg_rdata[B_SUCC] = succ_flag;
                reg_rdata[B_SPD_LO +: SPD_W] = cur_speed;
            end
            ADDR_W'(A_CTRL):     reg_rdata[B_START]  = start_bit;
            ADDR_W'(A_CAP):      reg_rdata[B_SPD_LO +: SPD_W] = link_cap_speed;
            ADDR_W'(A_REASON):   reg_rdata[B_REASON] = reason_bit;
            ADDR_W'(A_LOCAL_EN): reg_rdata[B_FIN]    = local_en;
            ADDR_W'(A_TOP_STAT): reg_rdata[B_MACIRQ] = top_stat;
            ADDR_W'(A_TOP_EN):   reg_rdata[B_MACIRQ] = top_en;
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/link_rate_ctrl.sv
module link_rate_ctrl
    import lrc_pkg::*;
#(
    parameter int ADDR_W         = 3,
    parameter int HOLDOFF_CYCLES = 40_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        link_cap_speed,
    output logic              train_req,
    output logic              train_reason,
    input  logic              train_done,
    input  logic              train_ok,
    input  logic [3:0]        train_speed,
    input  logic              link_in_l0,
    output logic              irq
);

    logic start_wr, accept, finish, finish_ok;
    logic fin_flag, succ_flag, fail_flag, start_bit;
    logic local_en, top_en, top_stat;
    logic [SPD_W-1:0] cur_speed;

    lrc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_cap_speed(link_cap_speed), .train_speed(train_speed),
        .accept(accept), .finish(finish), .finish_ok(finish_ok), .top_stat(top_stat),
        .start_wr(start_wr), .fin_flag(fin_flag), .succ_flag(succ_flag), .fail_flag(fail_flag),
        .start_bit(start_bit), .cur_speed(cur_speed), .reason_bit(train_reason),
        .local_en(local_en), .top_en(top_en)
    );

    lrc_fsm #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_wr(start_wr), .fin_pending(fin_flag), .start_busy(start_bit),
        .train_done(train_done), .train_ok(train_ok), .link_in_l0(link_in_l0),
        .accept(accept), .finish(finish), .finish_ok(finish_ok), .train_req(train_req)
    );

    lrc_irq u_irq (
        .fin_flag(fin_flag), .local_en(local_en), .top_en(top_en),
        .top_stat(top_stat), .irq(irq)
    );

endmodule

// File: rtl/link_rate_ctrl_chk.sv
module link_rate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic       train_req,
    input logic       train_done,
    input logic       train_ok,
    input logic       irq,
    input logic       fin_flag,
    input logic       succ_flag,
    input logic       fail_flag,
    input logic       start_bit,
    input logic [3:0] cur_speed
);

    p_req_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_req) |-> $past(reg_we));

    p_req_has_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        train_req |-> start_bit);

    p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (train_req && train_done) |=> (fin_flag && (succ_flag != fail_flag) && !start_bit));

    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(succ_flag && fail_flag));

    p_fail_keeps_speed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (train_req && train_done && !train_ok) |=> $stable(cur_speed));

    p_irq_needs_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fin_flag);

endmodule

bind link_rate_ctrl link_rate_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
    .train_req(train_req), .train_done(train_done), .train_ok(train_ok), .irq(irq),
    .fin_flag(fin_flag), .succ_flag(succ_flag), .fail_flag(fail_flag),
    .start_bit(start_bit), .cur_speed(cur_speed)
);

// File: tb/sim_link_rate_ctrl.sv
module sim_link_rate_ctrl;

    localparam int HOLD = 20;
    localparam logic [2:0] W_STATUS = 3'd0, W_CTRL = 3'd1, W_CAP = 3'd2, W_REASON = 3'd3,
                           W_LEN = 3'd4, W_TSTAT = 3'd5, W_TEN = 3'd6;
    localparam logic [31:0] START = 32'h0100_0000;
    localparam logic [31:0] CLR_ALL = 32'h0000_00D0;

    // {train_ok, train_speed}
    localparam logic [4:0] VEC [0:4] = '{5'b1_0010, 5'b0_0010, 5'b1_0001, 5'b0_0011, 5'b1_0010};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0] link_cap_speed = 4'd2;
    logic train_req, train_reason, irq;
    logic train_done = 1'b0;
    logic train_ok = 1'b0;
    logic [3:0] train_speed = '0;
    logic link_in_l0 = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    link_rate_ctrl #(.ADDR_W(3), .HOLDOFF_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_cap_speed(link_cap_speed),
        .train_req(train_req), .train_reason(train_reason), .train_done(train_done),
        .train_ok(train_ok), .train_speed(train_speed), .link_in_l0(link_in_l0), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic complete(input logic ok, input logic [3:0] spd);
        while (!train_req) @(negedge clk);
        train_done = 1'b1; train_ok = ok; train_speed = spd;
        @(negedge clk);
        train_done = 1'b0; train_ok = 1'b0; train_speed = '0;
    endtask

    task automatic pulse_l0();
        link_in_l0 = 1'b1;
        @(negedge clk);
        link_in_l0 = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100_000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0] exp_spd;
        exp_spd = 4'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(W_STATUS, d); check("R1 status", d, 32'h0001_0000);
        rd(W_CTRL, d);   check("R1 ctrl", d, 32'h0);
        rd(W_REASON, d); check("R1 reason", d, 32'h8000_0000);
        rd(W_LEN, d);    check("R1 local_en", d, 32'h0);
        rd(W_TSTAT, d);  check("R1 top_stat", d, 32'h0);
        rd(W_TEN, d);    check("R1 top_en", d, 32'h0);
        check("R1 req/irq", {30'd0, train_req, irq}, 32'h0);

        // table of change outcomes
        for (int i = 0; i < 5; i++) begin
            logic ok;
            logic [3:0] spd;
            {ok, spd} = VEC[i];
            wr(W_STATUS, CLR_ALL);
            wr(W_CTRL, START);
            rd(W_CTRL, d); check("R2 start reads 1", d, START);
            check("R2 req high", {31'd0, train_req}, 32'd1);
            complete(ok, spd);
            if (ok) exp_spd = spd;
            rd(W_STATUS, d);
            check("R3 flags", {24'd0, d[7:0]}, ok ? 32'h90 : 32'h50);
            check("R4 speed", {28'd0, d[19:16]}, {28'd0, exp_spd});
            rd(W_CTRL, d); check("R3 start cleared", d, 32'h0);
            check("R3 req low", {31'd0, train_req}, 32'd0);
            if (!ok) begin
                wr(W_STATUS, CLR_ALL);
                wr(W_CTRL, START);
                rd(W_CTRL, d); check("R10 locked start ignored", d, 32'h0);
                pulse_l0();
                repeat (HOLD - 1) @(negedge clk);
                wr(W_CTRL, START);
                rd(W_CTRL, d); check("R10 last holdoff cycle ignored", d, 32'h0);
                rd(W_STATUS, d); check("R11 no flags", {24'd0, d[7:0]}, 32'h0);
                check("R11 no req", {31'd0, train_req}, 32'd0);
                wr(W_CTRL, START);
                rd(W_CTRL, d); check("R10 accepted after holdoff", d, START);
                complete(1'b1, exp_spd);
            end
        end

        // R6: finished flag still set -> start ignored
        wr(W_CTRL, START);
        rd(W_CTRL, d); check("R6 fin pending ignored", d, 32'h0);
        check("R6 no req", {31'd0, train_req}, 32'd0);
        // R5: writing zero keeps flags, writing one clears
        wr(W_STATUS, 32'h0);
        rd(W_STATUS, d); check("R5 zero write keeps", {24'd0, d[7:0]}, 32'h90);
        wr(W_STATUS, 32'h10);
        rd(W_STATUS, d); check("R5 clear fin only", {24'd0, d[7:0]}, 32'h80);
        wr(W_STATUS, 32'h80);
        rd(W_STATUS, d); check("R5 clear succ", {24'd0, d[7:0]}, 32'h00);
        // R6: start while already in progress
        wr(W_CTRL, START);
        wr(W_CTRL, START);
        rd(W_CTRL, d); check("R6 second start no change", d, START);
        complete(1'b1, 4'd2);
        rd(W_CTRL, d); check("R6 single completion", d, 32'h0);
        @(negedge clk);
        check("R6 no re-request", {31'd0, train_req}, 32'd0);

        // R7 capability
        rd(W_CAP, d); check("R7 cap", d, 32'h0002_0000);
        link_cap_speed = 4'd1;
        wr(W_CAP, 32'hFFFF_FFFF);
        rd(W_CAP, d); check("R7 cap follows pin", d, 32'h0001_0000);

        // R8 reason
        check("R8 reason out", {31'd0, train_reason}, 32'd1);
        wr(W_REASON, 32'h0);
        rd(W_REASON, d); check("R8 reason cleared", d, 32'h0);
        check("R8 reason out low", {31'd0, train_reason}, 32'd0);

        // R9 interrupt chain (finished flag still set)
        wr(W_LEN, 32'h10);
        wr(W_TEN, 32'h2000);
        rd(W_TSTAT, d); check("R9 top stat", d, 32'h2000);
        check("R9 irq on", {31'd0, irq}, 32'd1);
        wr(W_TEN, 32'h0);
        check("R9 top mask", {31'd0, irq}, 32'd0);
        rd(W_TSTAT, d); check("R9 stat unmasked", d, 32'h2000);
        wr(W_TEN, 32'h2000);
        wr(W_LEN, 32'h0);
        rd(W_TSTAT, d); check("R9 local mask", d, 32'h0);
        check("R9 irq off local", {31'd0, irq}, 32'd0);
        wr(W_LEN, 32'h10);
        check("R9 irq back", {31'd0, irq}, 32'd1);
        wr(W_STATUS, 32'h10);
        check("R9 ack drops irq", {31'd0, irq}, 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule